// File: doc/BRIEF.md
# Acquisition Time Base Sequencer

This block paces one digitizer capture around a trigger event. It runs from a fixed 100 MHz reference clock. A programmable divider derives a sample-enable pulse from that clock, and the capture memory uses the pulse to take one sample. When the host starts a capture, the block first collects a programmed number of samples that precede the trigger. It then arms the trigger logic and waits for the trigger logic to report that its trigger condition has been met.

When a trigger is accepted, the block counts a programmed number of samples that follow it. It then stops the sample pulses and reports completion to the host, and holds that report until the host acknowledges it. The host can abort a capture at any point. The divider ratio, the pre-trigger length and the post-trigger length are captured into internal registers only while the block is idle.

Top module: `acq_timebase`

## Requirements
- R1: After reset the block is idle, and `arm`, `done` and `sample_en` are all low.
- R2: While a capture runs, `sample_en` is a single-cycle pulse that repeats every `div_r + 1` reference cycles, where `div_r` is the stored divider value (0 means a pulse on every cycle).
- R3: After a start, `arm` rises only once exactly `pre_r` sample pulses have been issued. It rises in the cycle after the last of these pulses. If `pre_r` is 0, `arm` rises in the cycle after the start is taken, and no pulse is required.
- R4: `trig` has no effect while the block is idle, collecting pre-trigger samples, or done. Holding it high before arming neither advances nor shortens the capture.
- R5: A `trig` taken while `arm` is high drops `arm` at the next edge. The block then issues exactly `post_r` further sample pulses, after which `done` rises. If `post_r` is 0, `done` rises in the cycle after the trigger. `arm` and `done` are never high together.
- R6: `done` stays high until `done_clr` is pulsed, which returns the block to idle. A `start` pulse while done is ignored.
- R7: `abort` returns the block to idle at the next edge from any state, and clears `arm`, `done` and `sample_en`. It wins over a `trig` in the same cycle.
- R8: `cfg_we` loads `cfg_div`, `cfg_pre` and `cfg_post` only while the block is idle; writes at other times are discarded. A write in the same cycle as `start` takes effect for that capture.
- R9: `sample_en` is never high while the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only when idle |
| cfg_div | input | DIV_W | Divider value; sample period is value + 1 clocks |
| cfg_pre | input | CNT_W | Number of samples to take before arming |
| cfg_post | input | CNT_W | Number of samples to take after the trigger |
| start | input | 1 | Host pulse that begins a capture from idle |
| abort | input | 1 | Host pulse that returns the block to idle |
| done_clr | input | 1 | Host acknowledge of completion |
| trig | input | 1 | Trigger-condition-met indication from the trigger logic |
| arm | output | 1 | Ready for a trigger; pre-trigger samples complete |
| sample_en | output | 1 | One-cycle sample-enable pulse per divided period |
| done | output | 1 | Capture complete, held until acknowledged |

## Verification
Two pairs of events can fall in the same cycle. An abort can arrive together with an accepted trigger while the block is armed. A configuration write can arrive together with the start pulse. The bench drives abort and trig high in the same cycle while armed, and then checks that `arm` and `done` fall and that neither `done` nor any sample pulse appears afterwards. Every capture in the vector table writes its configuration in the same cycle as `start`, so each pulse count that the bench compares against the table also shows that the values written in that cycle were used.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_t;
endpackage

// File: rtl/acq_rate_div.sv
module acq_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)        phase <= '0;
    else if (phase == ratio) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = run && (phase == ratio);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && ratio != '0 && run) |=> !tick); // R2
endmodule

// File: rtl/acq_span_cnt.sv
module acq_span_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  input  logic             step,
  output logic             fin
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                          remain <= '0;
    else if (load)                    remain <= limit;
    else if (step && remain != '0)    remain <= remain - 1'b1;
  end

  assign fin = step && (remain == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_SPAN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && remain == '0) |=> remain == '0); // R5
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       abort,
  input  logic       done_clr,
  input  logic       trig,
  input  logic       pre_zero,
  input  logic       post_zero,
  input  logic       pre_fin,
  input  logic       post_fin,
  output acq_state_t state,
  output logic       pre_load,
  output logic       post_load,
  output logic       running,
  output logic       arm_q,
  output logic       done_q
);
  acq_state_t nxt;

  always_comb begin
    nxt = state;
    if (abort) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (start)    nxt = pre_zero  ? ST_ARMED : ST_PRE;
        ST_PRE:   if (pre_fin)  nxt = ST_ARMED;
        ST_ARMED: if (trig)     nxt = post_zero ? ST_DONE  : ST_POST;
        ST_POST:  if (post_fin) nxt = ST_DONE;
        ST_DONE:  if (done_clr) nxt = ST_IDLE;
        default:                nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      arm_q  <= (nxt == ST_ARMED);
      done_q <= (nxt == ST_DONE);
    end
  end

  assign pre_load  = (state == ST_IDLE) && start;
  assign post_load = (state == ST_ARMED) && trig && !abort;
  assign running   = (state == ST_PRE) || (state == ST_ARMED) || (state == ST_POST);

  AST_PRE_NO_POST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |=> (state != ST_POST)); // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_q && !done_clr && !abort) |=> done_q); // R6
endmodule

// File: rtl/acq_timebase.sv
module acq_timebase
  import acq_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  input  logic             start,
  input  logic             abort,
  input  logic             done_clr,
  input  logic             trig,
  output logic             arm,
  output logic             sample_en,
  output logic             done
);
  acq_state_t       state;
  logic [DIV_W-1:0] div_r;
  logic [CNT_W-1:0] pre_r, post_r, pre_lim;
  logic             idle, cfg_take, running, tick;
  logic             pre_load, post_load, pre_fin, post_fin;

  assign idle     = (state == ST_IDLE);
  assign cfg_take = cfg_we && idle;
  assign pre_lim  = cfg_take ? cfg_pre : pre_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_r  <= '0;
      pre_r  <= '0;
      post_r <= '0;
    end else if (cfg_take) begin
      div_r  <= cfg_div;
      pre_r  <= cfg_pre;
      post_r <= cfg_post;
    end
  end

  acq_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(running), .ratio(div_r), .tick(tick)
  );

  acq_span_cnt #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .load(pre_load), .limit(pre_lim),
    .step(tick && state == ST_PRE), .fin(pre_fin)
  );

  acq_span_cnt #(.CNT_W(CNT_W)) u_post (
    .clk(clk), .rst(rst), .load(post_load), .limit(post_r),
    .step(tick && state == ST_POST), .fin(post_fin)
  );

  acq_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .done_clr(done_clr),
    .trig(trig), .pre_zero(pre_lim == '0), .post_zero(post_r == '0),
    .pre_fin(pre_fin), .post_fin(post_fin), .state(state),
    .pre_load(pre_load), .post_load(post_load), .running(running),
    .arm_q(arm), .done_q(done)
  );

  assign sample_en = tick;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(div_r) && $stable(pre_r) && $stable(post_r))); // R8
  AST_SEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !sample_en); // R9
  AST_ARM_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(arm && done)); // R5
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!arm && !done && !sample_en)); // R7
endmodule

// File: tb/acq_timebase_tb_top.sv
module acq_timebase_tb_top;
  localparam int DIV_W = 8;
  localparam int CNT_W = 12;
  localparam int NVEC  = 8;
  // {trig held before arming, div, pre, post}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 8'd0, 12'd3, 12'd2},
    {1'b1, 8'd1, 12'd4, 12'd3},
    {1'b0, 8'd3, 12'd2, 12'd5},
    {1'b0, 8'd1, 12'd0, 12'd0},
    {1'b1, 8'd2, 12'd0, 12'd4},
    {1'b0, 8'd4, 12'd5, 12'd0},
    {1'b1, 8'd0, 12'd1, 12'd1},
    {1'b0, 8'd7, 12'd3, 12'd3}
  };

  logic clk = 1'b0;
  logic rst, cfg_we, start, abort, done_clr, trig;
  logic [DIV_W-1:0] cfg_div;
  logic [CNT_W-1:0] cfg_pre, cfg_post;
  logic arm, sample_en, done;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  acq_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .start(start), .abort(abort), .done_clr(done_clr),
    .trig(trig), .arm(arm), .sample_en(sample_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_acq(input bit do_cfg, input int dv, input int pr, input int po,
                         input int edv, input int epr, input int epo,
                         input bit early, input bit busy_write);
    int pulses, last, cyc, gap_bad;
    @(negedge clk);
    cfg_we = do_cfg; cfg_div = dv[DIV_W-1:0]; cfg_pre = pr[CNT_W-1:0];
    cfg_post = po[CNT_W-1:0]; start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    pulses = 0; last = -1; cyc = 0; gap_bad = 0;
    while (!arm && cyc < 3000) begin
      if (sample_en) begin
        if (last >= 0 && cyc - last != edv + 1) gap_bad = cyc - last;
        last = cyc; pulses++;
      end
      trig = early;
      @(negedge clk);
      cyc++;
    end
    trig = 1'b0;
    chk(arm == 1'b1, "R3 arm reached", arm, 1);
    chk(pulses == epr, "R3 pre-trigger pulses", pulses, epr);
    chk(gap_bad == 0, "R2 pulse spacing", gap_bad, edv + 1);
    if (busy_write) begin
      cfg_we = 1'b1; cfg_div = 8'd9; cfg_pre = 12'd9; cfg_post = 12'd9;
    end
    repeat (3) @(negedge clk);
    cfg_we = 1'b0;
    chk(arm && !done, "R4 still armed", arm, 1);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(!arm, "R5 arm drops", arm, 0);
    pulses = 0; cyc = 0;
    while (!done && cyc < 3000) begin
      if (sample_en) pulses++;
      @(negedge clk);
      cyc++;
    end
    chk(pulses == epo, "R5 post-trigger pulses", pulses, epo);
    trig = 1'b1; start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done && !arm && !sample_en, "R6 done holds, R9 quiet", {done, arm, sample_en}, 4);
    end
    trig = 1'b0;
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(!done && !arm && !sample_en, "R6 clear to idle", {done, arm, sample_en}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 0; start = 0; abort = 0; done_clr = 0; trig = 0;
    cfg_div = '0; cfg_pre = '0; cfg_post = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!arm && !done && !sample_en, "R1 reset state", {arm, done, sample_en}, 0);
    // R4: trig while idle does nothing
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    chk(!arm && !done && !sample_en, "R4 idle trig, R9", {arm, done, sample_en}, 0);

    // vector table: cfg written together with start (R8)
    for (int v = 0; v < NVEC; v++) begin
      run_acq(1'b1, int'(VEC[v][31:24]), int'(VEC[v][23:12]), int'(VEC[v][11:0]),
              int'(VEC[v][31:24]), int'(VEC[v][23:12]), int'(VEC[v][11:0]),
              VEC[v][32], 1'b0);
    end

    // R8: write while busy is discarded; next run reuses stored values
    run_acq(1'b1, 1, 3, 2, 1, 3, 2, 1'b0, 1'b1);
    run_acq(1'b0, 0, 0, 0, 1, 3, 2, 1'b0, 1'b0);

    // R7: abort during pre-trigger collection
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 8'd2; cfg_pre = 12'd20; cfg_post = 12'd3; start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!arm && !done && !sample_en, "R7 abort in pre", {arm, done, sample_en}, 0);
    repeat (70) begin
      @(negedge clk);
      chk(!arm && !sample_en, "R7 stays idle", {arm, sample_en}, 0);
    end

    // R7: abort together with trig while armed
    @(negedge clk);
    cfg_we = 1'b1; cfg_pre = 12'd0; start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    chk(arm, "R3 zero pre arms next cycle", arm, 1);
    abort = 1'b1; trig = 1'b1;
    @(negedge clk);
    abort = 1'b0; trig = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk(!arm && !done && !sample_en, "R7 abort beats trig", {arm, done, sample_en}, 0);
      @(negedge clk);
    end

    // R7: abort during post-trigger counting
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk(!done && !sample_en, "R7 abort in post", {done, sample_en}, 0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule